// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block sits in the memory stage of a 32-bit RISC core that has 5-bit register fields. It takes one instruction word and the value read from that instruction's base register. It sorts the word into a byte, word or FP (64-bit-class) load or store, or into a non-memory operation. For a memory operation it produces the effective address, the access size code, read and write strobes, a register-byte enable, the base-register index, the data register index and a flag that picks the integer or FP register file.

Loads and stores place the offset differently. A load takes its 16-bit offset from the low half of the word. A store keeps its data-source register in the middle field, so its offset is split: the high 5 bits come from bits 20:16 and the low 11 bits from bits 10:0. In both cases the offset's low bits are cleared according to the access size before it is sign-extended and added to the base. The add wraps modulo 2^32.

Requests enter on a valid/ready input and results leave on a valid/ready output, through one register stage. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or the consumer has `out_ready` high. While `out_valid` is high and `out_ready` is low, every output holds steady and no new request is taken.

Top module: `lsu_ea_gen`

## Requirements
- R1: `out_base_idx` equals instruction bits 25:21. `out_data_idx` equals bits 20:16 for a load and bits 15:11 for a store.
- R2: For a load, `out_ea` equals the base value plus the sign extension of the (masked) 16-bit field in bits 15:0.
- R3: For a store, the 16-bit offset is bits 20:16 as its high 5 bits joined to bits 10:0 as its low 11 bits. It is then masked, sign-extended and added to the base.
- R4: Offset masking before sign extension: byte accesses keep all 16 bits, word accesses clear bits 1:0, and FP accesses clear bits 2:0.
- R5: Opcode (bits 31:26) classes: 0x00 and 0x01 are byte loads, 0x04 and 0x05 word loads, 0x08 and 0x09 FP loads, 0x03 a byte store, 0x06 and 0x07 word stores, 0x0A and 0x0B FP stores. Loads raise `out_rd` and stores raise `out_wr`. `out_size` is 0 for byte, 1 for word and 2 for FP.
- R6: `out_bytes` is 4'b0001 for byte accesses (only the low 8 bits of the data register are used) and 4'b1111 for word and FP accesses.
- R7: `out_fp` is 1 exactly for FP loads and stores, and 0 for integer accesses.
- R8: The EA adder wraps modulo 2^32 and has no overflow indication.
- R9: Every other opcode (including 0x02) gives `out_rd`=0, `out_wr`=0, `out_fp`=0, `out_size`=0, `out_bytes`=0, `out_data_idx`=0 and `out_ea`=0.
- R10: A request accepted at one rising edge appears with `out_valid`=1 after the next rising edge, which is a latency of one cycle.
- R11: While `out_valid`=1 and `out_ready`=0, all outputs hold their values and `in_ready`=0. Otherwise `in_ready`=1.
- R12: While `rst_n`=0 and after its release, `out_valid` is 0 until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_instr | input | 32 | Instruction word |
| in_base | input | 32 | Base register value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_base_idx | output | 5 | Base register index |
| out_data_idx | output | 5 | Load destination or store source index |
| out_ea | output | 32 | Effective address |
| out_size | output | 2 | 0 byte, 1 word, 2 FP |
| out_rd | output | 1 | Read strobe |
| out_wr | output | 1 | Write strobe |
| out_fp | output | 1 | 1 selects the FP register file |
| out_bytes | output | 4 | Data register byte enable |

## Verification
The assertions take for granted that the consumer obeys the handshake: once it sees `out_valid`, it may hold `out_ready` low for any number of cycles. They also assume `rst_n` is low for at least one edge before any request. The bench changes its inputs only on falling edges, keeps reset low for several cycles, and stalls the output only with `out_ready`. It therefore never leaves that envelope, while the instruction words cover every memory opcode, two non-memory opcodes and offsets at both sign extremes.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
  localparam int REG_IDX_W = 5;
  localparam int OPC_W     = 6;
  localparam int BYTES_W   = 4;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } size_e;

  typedef struct packed {
    logic  is_ld;
    logic  is_st;
    logic  is_fp;
    size_e size;
  } acc_t;
endpackage

// File: rtl/lsag_decode.sv
module lsag_decode
  import lsag_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output acc_t             acc
);
  always_comb begin
    acc = '{is_ld: 1'b0, is_st: 1'b0, is_fp: 1'b0, size: SZ_BYTE};
    unique case (opcode)
      6'h00, 6'h01: begin acc.is_ld = 1'b1; acc.size = SZ_BYTE;  end
      6'h04, 6'h05: begin acc.is_ld = 1'b1; acc.size = SZ_WORD;  end
      6'h08, 6'h09: begin acc.is_ld = 1'b1; acc.size = SZ_DWORD; acc.is_fp = 1'b1; end
      6'h03:        begin acc.is_st = 1'b1; acc.size = SZ_BYTE;  end
      6'h06, 6'h07: begin acc.is_st = 1'b1; acc.size = SZ_WORD;  end
      6'h0a, 6'h0b: begin acc.is_st = 1'b1; acc.size = SZ_DWORD; acc.is_fp = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/lsag_offset.sv
module lsag_offset
  import lsag_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int LOW_W = 11
) (
  input  logic [31:0]     instr,
  input  acc_t            acc,
  output logic [XLEN-1:0] offset
);
  localparam int HIGH_W = OFF_W - LOW_W;

  logic [OFF_W-1:0] raw;
  logic [OFF_W-1:0] masked;

  // Stores displace the offset's high part into the destination field.
  always_comb begin
    if (acc.is_st)
      raw = {instr[16 +: HIGH_W], instr[LOW_W-1:0]};
    else
      raw = instr[OFF_W-1:0];
  end

  always_comb begin
    unique case (acc.size)
      SZ_WORD:  masked = raw & ~OFF_W'(3);
      SZ_DWORD: masked = raw & ~OFF_W'(7);
      default:  masked = raw;
    endcase
  end

  assign offset = {{(XLEN-OFF_W){masked[OFF_W-1]}}, masked};
endmodule

// File: rtl/lsag_outreg.sv
module lsag_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen
  import lsag_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int LOW_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_instr,
  input  logic [XLEN-1:0] in_base,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [4:0]      out_base_idx,
  output logic [4:0]      out_data_idx,
  output logic [XLEN-1:0] out_ea,
  output logic [1:0]      out_size,
  output logic            out_rd,
  output logic            out_wr,
  output logic            out_fp,
  output logic [3:0]      out_bytes
);
  localparam int PAY_W = XLEN + 2*REG_IDX_W + 2 + 3 + BYTES_W;

  acc_t                 acc;
  logic                 is_mem;
  logic [XLEN-1:0]      offset;
  logic [XLEN-1:0]      ea_c;
  logic [REG_IDX_W-1:0] didx_c;
  logic [BYTES_W-1:0]   bytes_c;
  logic [PAY_W-1:0]     pay_in, pay_out;

  lsag_decode u_dec (
    .opcode (in_instr[31:26]),
    .acc    (acc)
  );

  lsag_offset #(.XLEN(XLEN), .OFF_W(OFF_W), .LOW_W(LOW_W)) u_off (
    .instr  (in_instr),
    .acc    (acc),
    .offset (offset)
  );

  assign is_mem = acc.is_ld || acc.is_st;

  // Wrapping add: carry out is discarded.
  always_comb begin
    ea_c = '0;
    if (is_mem) ea_c = in_base + offset;
  end

  always_comb begin
    didx_c = '0;
    if (acc.is_ld)      didx_c = in_instr[20:16];
    else if (acc.is_st) didx_c = in_instr[15:11];
  end

  always_comb begin
    bytes_c = '0;
    if (is_mem) bytes_c = (acc.size == SZ_BYTE) ? BYTES_W'(1) : '1;
  end

  assign pay_in = {in_instr[25:21], didx_c, ea_c, acc.size,
                   acc.is_ld, acc.is_st, acc.is_fp, bytes_c};

  lsag_outreg #(.W(PAY_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign {out_base_idx, out_data_idx, out_ea, out_size,
          out_rd, out_wr, out_fp, out_bytes} = pay_out;

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_rd, out_wr}));
  assert_fp_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fp) |-> (out_size == 2'd2 && (out_rd || out_wr)));
  assert_byte_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_rd || out_wr) && out_size == 2'd0) |-> (out_bytes == 4'b0001));
  assert_nonmem_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_rd && !out_wr) |-> (out_bytes == 4'b0000 && !out_fp));
  assert_ready_rule_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  assert_reset_idle_R12: assert property (@(posedge clk)
    $past(!rst_n) |-> !out_valid);
endmodule

// File: tb/sim_lsu_ea_gen.sv
`timescale 1ns/1ps
module sim_lsu_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [31:0] in_instr = '0, in_base = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [4:0]  out_base_idx, out_data_idx;
  logic [31:0] out_ea;
  logic [1:0]  out_size;
  logic        out_rd, out_wr, out_fp;
  logic [3:0]  out_bytes;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lsu_ea_gen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_base(in_base), .out_valid(out_valid),
    .out_ready(out_ready), .out_base_idx(out_base_idx),
    .out_data_idx(out_data_idx), .out_ea(out_ea), .out_size(out_size),
    .out_rd(out_rd), .out_wr(out_wr), .out_fp(out_fp), .out_bytes(out_bytes)
  );

  typedef struct packed {
    logic [31:0] ins;
    logic [31:0] base;
    logic [31:0] ea;
    logic        rd;
    logic        wr;
    logic        fp;
    logic [1:0]  sz;
    logic [4:0]  di;
    logic [3:0]  be;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h00670005, 32'h00001000, 32'h00001005, 1'b1, 1'b0, 1'b0, 2'd0, 5'd7,  4'b0001}, // R2 byte load
    '{32'h0422FFFF, 32'h00000000, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b0, 2'd0, 5'd2,  4'b0001}, // R2 negative
    '{32'h10890007, 32'h00000100, 32'h00000104, 1'b1, 1'b0, 1'b0, 2'd1, 5'd9,  4'b1111}, // R4 word mask
    '{32'h14018003, 32'h00010000, 32'h00008000, 1'b1, 1'b0, 1'b0, 2'd1, 5'd1,  4'b1111}, // R4 mask+sign
    '{32'h20BF000F, 32'h00002000, 32'h00002008, 1'b1, 1'b0, 1'b1, 2'd2, 5'd31, 4'b1111}, // R7 fp load
    '{32'h24430010, 32'hFFFFFFF8, 32'h00000008, 1'b1, 1'b0, 1'b1, 2'd2, 5'd3,  4'b1111}, // R8 wrap
    '{32'h0D013023, 32'h00004000, 32'h00004823, 1'b0, 1'b1, 1'b0, 2'd0, 5'd6,  4'b0001}, // R3 split
    '{32'h0C1F07FF, 32'h00000010, 32'h0000000F, 1'b0, 1'b1, 1'b0, 2'd0, 5'd0,  4'b0001}, // R3 -1
    '{32'h18F06003, 32'h00020000, 32'h00018000, 1'b0, 1'b1, 1'b0, 2'd1, 5'd12, 4'b1111}, // R3 word neg
    '{32'h1C20080E, 32'h00000030, 32'h0000003C, 1'b0, 1'b1, 1'b0, 2'd1, 5'd1,  4'b1111}, // R4 store mask
    '{32'h28602017, 32'h00000500, 32'h00000510, 1'b0, 1'b1, 1'b1, 2'd2, 5'd4,  4'b1111}, // R4 fp mask
    '{32'h2FFFFFFC, 32'h00000100, 32'h000000F8, 1'b0, 1'b1, 1'b1, 2'd2, 5'd31, 4'b1111}, // R7 fp store
    '{32'h08A3F000, 32'h00001234, 32'h00000000, 1'b0, 1'b0, 1'b0, 2'd0, 5'd0,  4'b0000}, // R9 op 0x02
    '{32'h68000000, 32'h00000055, 32'h00000000, 1'b0, 1'b0, 1'b0, 2'd0, 5'd0,  4'b0000}  // R9 op 0x1A
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_vec(input vec_t v);
    chk("R10 out_valid", {31'd0, out_valid}, 32'd1);
    chk("R1 base idx", {27'd0, out_base_idx}, {27'd0, v.ins[25:21]});
    chk("R1 data idx", {27'd0, out_data_idx}, {27'd0, v.di});
    chk("R2/R3 ea", out_ea, v.ea);
    chk("R5 strobes", {30'd0, out_rd, out_wr}, {30'd0, v.rd, v.wr});
    chk("R5 size", {30'd0, out_size}, {30'd0, v.sz});
    chk("R7 fp", {31'd0, out_fp}, {31'd0, v.fp});
    chk("R6 bytes", {28'd0, out_bytes}, {28'd0, v.be});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R12 valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R11 ready idle", {31'd0, in_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      in_instr = VECS[i].ins;
      in_base  = VECS[i].base;
      @(negedge clk);
      in_valid = 1'b0;
      check_vec(VECS[i]);
      @(negedge clk);
      chk("R10 single beat", {31'd0, out_valid}, 32'd0);
    end

    // Back-pressure: stall the consumer (R11)
    out_ready = 1'b0;
    in_valid = 1'b1; in_instr = VECS[2].ins; in_base = VECS[2].base;
    @(negedge clk);
    check_vec(VECS[2]);
    chk("R11 ready low in stall", {31'd0, in_ready}, 32'd0);
    in_instr = VECS[9].ins; in_base = VECS[9].base;
    @(negedge clk);
    chk("R11 held ea", out_ea, VECS[2].ea);
    chk("R11 held idx", {27'd0, out_data_idx}, {27'd0, VECS[2].di});
    chk("R11 held valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    check_vec(VECS[9]);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10 drained", {31'd0, out_valid}, 32'd0);

    // Back-to-back stream with ready high (R10)
    in_valid = 1'b1; in_instr = VECS[4].ins; in_base = VECS[4].base;
    @(negedge clk);
    check_vec(VECS[4]);
    in_instr = VECS[11].ins; in_base = VECS[11].base;
    @(negedge clk);
    check_vec(VECS[11]);
    in_valid = 1'b0;

    // Reset while holding a result (R12)
    out_ready = 1'b0;
    in_valid = 1'b1; in_instr = VECS[0].ins; in_base = VECS[0].base;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12 reset clears", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    chk("R12 stays idle", {31'd0, out_valid}, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule